// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM Generator

This block drives one pulse-width-modulated output. An 8-bit period timer counts up from zero. Each timer step is split into four quarter phases, so a 2-bit sub-count extends the timer and the duty compare is 10 bits wide. A prescaler stretches every timer step by 1, 4 or 16. When the timer has reached the period register and the current step ends, the timer returns to zero. At that same edge a new period starts: the output goes high and the pending duty value is copied into a shadow register.

Software may write the duty value at any time, as an 8-bit upper part and a 2-bit lower part. The compare logic uses only the shadow, so a write made in the middle of a period cannot shorten or lengthen the pulse that is already running. The shadow can be read back through `duty_active`. A duty of zero keeps the output low. A duty longer than the period keeps it high.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: After a synchronous reset, `pwm_out` is 0 and `duty_active` is 0. With a nonzero duty applied, the first rising edge of `pwm_out` comes exactly (period+1)·4·P clocks after reset is released.
- R2: `prescale_sel` encodes the prescale factor P: code 0 gives 1, code 1 gives 4, codes 2 and 3 give 16. The output period is (period+1)·4·P input clocks.
- R3: D is the concatenation {duty_hi, duty_lo}, with duty_hi as the upper 8 bits. For 0 < D < (period+1)·4, `pwm_out` is high for exactly D·P clocks at the start of each period.
- R4: A duty write made during a period does not change the pulse of that period. The new value shapes the pulse of the following period.
- R5: `duty_active` holds the shadow value. It changes only at a period boundary, where it takes the {duty_hi, duty_lo} value present at that edge.
- R6: When the value latched at a period boundary is 0, `pwm_out` stays low for the whole period.
- R7: When D ≥ (period+1)·4, `pwm_out` is never cleared and stays high across consecutive periods.
- R8: `pwm_out` rises only at a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| prescale_sel | input | 2 | Prescale code: 0 for ÷1, 1 for ÷4, 2 or 3 for ÷16 |
| period | input | 8 | Terminal value of the period timer |
| duty_hi | input | 8 | Upper 8 bits of the pending duty |
| duty_lo | input | 2 | Lower 2 bits of the pending duty |
| duty_active | output | 10 | Shadow duty currently used by the compare |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach is a duty write that lands inside a running pulse. The bench detects the rising edge of the output at a falling clock edge. In that same half cycle it writes a different duty. It then checks two things: the width of the current pulse still matches the old value, and the next pulse matches the new one. Most other cases are corners of the duty range: zero, exactly one quarter step, one below the full period, equal to it, and above it. The bench reaches them by sweeping every duty value for small periods under every prescale code.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

   // Clamp a prescale code to the largest supported step index.
   function automatic int unsigned clamp_code(input int unsigned code, input int unsigned steps);
      return (code > steps) ? steps : code;
   endfunction

endpackage

// File: rtl/pwm_step_counter.sv
// Fine counter: counts input clocks inside one timer step and
// provides the sub-count phase of the position about to be entered.
module pwm_step_counter #(
   parameter int FRAC_W      = 2,
   parameter int PS_SEL_W    = 2,
   parameter int PS_STEPS    = 2,
   parameter int PS_STEP_LOG = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [PS_SEL_W-1:0] psel,
   output logic                step,
   output logic [FRAC_W-1:0]   sub_next
);
   import pwm_dbuf_pkg::*;

   localparam int FINE_W = FRAC_W + PS_STEP_LOG * PS_STEPS;
   localparam int NSEL   = PS_STEPS + 1;
   localparam int IDX_W  = (NSEL > 1) ? $clog2(NSEL) : 1;

   logic [FINE_W-1:0] fine_q, fine_d;
   logic [FINE_W-1:0] last_opt [NSEL];
   logic [FRAC_W-1:0] sub_opt  [NSEL];
   logic [IDX_W-1:0]  idx;

   always_comb idx = IDX_W'(clamp_code(int'(psel), PS_STEPS));

   for (genvar k = 0; k < NSEL; k++) begin : g_opt
      assign last_opt[k] = FINE_W'((64'd1 << (FRAC_W + PS_STEP_LOG * k)) - 64'd1);
      assign sub_opt[k]  = fine_d[PS_STEP_LOG * k +: FRAC_W];
   end

   // >= so that a smaller prescale written mid-step still terminates
   assign step     = (fine_q >= last_opt[idx]);
   assign fine_d   = step ? '0 : fine_q + 1'b1;
   assign sub_next = sub_opt[idx];

   always_ff @(posedge clk) begin
      if (rst) fine_q <= '0;
      else     fine_q <= fine_d;
   end
endmodule

// File: rtl/pwm_period_timer.sv
// Base period timer: advances once per step, clears after matching period.
module pwm_period_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic [TMR_W-1:0] period,
   output logic             wrap,
   output logic [TMR_W-1:0] tmr_q,
   output logic [TMR_W-1:0] tmr_d
);
   assign wrap = step && (tmr_q == period);

   always_comb begin
      if (wrap)      tmr_d = '0;
      else if (step) tmr_d = tmr_q + 1'b1;
      else           tmr_d = tmr_q;
   end

   always_ff @(posedge clk) begin
      if (rst) tmr_q <= '0;
      else     tmr_q <= tmr_d;
   end
endmodule

// File: rtl/pwm_duty_shadow.sv
// Shadow copy of the duty, loaded only at a period boundary.
module pwm_duty_shadow #(
   parameter int DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DUTY_W-1:0] pend,
   output logic [DUTY_W-1:0] shadow_q
);
   always_ff @(posedge clk) begin
      if (rst)       shadow_q <= '0;
      else if (load) shadow_q <= pend;
   end
endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen #(
   parameter int TMR_W       = 8,
   parameter int FRAC_W      = 2,
   parameter int PS_SEL_W    = 2,
   parameter int PS_STEPS    = 2,
   parameter int PS_STEP_LOG = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [PS_SEL_W-1:0]       prescale_sel,
   input  logic [TMR_W-1:0]          period,
   input  logic [TMR_W-1:0]          duty_hi,
   input  logic [FRAC_W-1:0]         duty_lo,
   output logic [TMR_W+FRAC_W-1:0]   duty_active,
   output logic                      pwm_out
);
   localparam int DUTY_W = TMR_W + FRAC_W;

   if (TMR_W < 1)                          begin : g_bad_tmr  $error("TMR_W must be positive");        end
   if (FRAC_W < 1)                         begin : g_bad_frac $error("FRAC_W must be positive");       end
   if (PS_STEP_LOG < FRAC_W)               begin : g_bad_log  $error("prescale step too fine");        end
   if ((2 ** PS_SEL_W) - 1 < PS_STEPS)     begin : g_bad_sel  $error("prescale code too narrow");      end

   logic                step;
   logic [FRAC_W-1:0]   sub_next;
   logic                wrap;
   logic [TMR_W-1:0]    tmr_q, tmr_d;
   logic [DUTY_W-1:0]   pend;
   logic [DUTY_W-1:0]   shadow_q;
   logic [DUTY_W-1:0]   pos_next;
   logic                pin_q, pin_d;

   assign pend = {duty_hi, duty_lo};

   pwm_step_counter #(
      .FRAC_W(FRAC_W), .PS_SEL_W(PS_SEL_W),
      .PS_STEPS(PS_STEPS), .PS_STEP_LOG(PS_STEP_LOG)
   ) u_step (
      .clk(clk), .rst(rst), .psel(prescale_sel),
      .step(step), .sub_next(sub_next)
   );

   pwm_period_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst(rst), .step(step), .period(period),
      .wrap(wrap), .tmr_q(tmr_q), .tmr_d(tmr_d)
   );

   pwm_duty_shadow #(.DUTY_W(DUTY_W)) u_shadow (
      .clk(clk), .rst(rst), .load(wrap), .pend(pend), .shadow_q(shadow_q)
   );

   // Compare against the position entered at this edge, so that the
   // high time equals duty * prescale clocks exactly.
   assign pos_next = {tmr_d, sub_next};

   always_comb begin
      if (wrap)                       pin_d = (pend != '0);
      else if (pos_next == shadow_q)  pin_d = 1'b0;
      else                            pin_d = pin_q;
   end

   always_ff @(posedge clk) begin
      if (rst) pin_q <= 1'b0;
      else     pin_q <= pin_d;
   end

   assign pwm_out     = pin_q;
   assign duty_active = shadow_q;
endmodule

// File: rtl/pwm_dbuf_gen_chk.sv
module pwm_dbuf_gen_chk #(
   parameter int TMR_W  = 8,
   parameter int FRAC_W = 2
) (
   input logic                    clk,
   input logic                    rst,
   input logic [TMR_W-1:0]        period,
   input logic [TMR_W-1:0]        duty_hi,
   input logic [FRAC_W-1:0]       duty_lo,
   input logic [TMR_W+FRAC_W-1:0] duty_active,
   input logic                    pwm_out,
   input logic                    wrap,
   input logic [TMR_W-1:0]        tmr_q
);
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(duty_active)); // R4
   AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
      wrap |=> duty_active == $past({duty_hi, duty_lo})); // R5
   AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (rst)
      wrap |=> tmr_q == '0); // R2
   AST_ZERO_NO_SET: assert property (@(posedge clk) disable iff (rst)
      (wrap && {duty_hi, duty_lo} == '0) |=> !pwm_out); // R6
   AST_SET_AT_START: assert property (@(posedge clk) disable iff (rst)
      (wrap && {duty_hi, duty_lo} != '0) |=> pwm_out); // R3
   AST_RISE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out) |-> $past(wrap)); // R8
   AST_CLEAR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      ($fell(pwm_out) && !$past(wrap)) |->
         $past(duty_active) <= {$past(period), {FRAC_W{1'b1}}}); // R7
endmodule

bind pwm_dbuf_gen pwm_dbuf_gen_chk #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_chk (
   .clk(clk), .rst(rst), .period(period), .duty_hi(duty_hi), .duty_lo(duty_lo),
   .duty_active(duty_active), .pwm_out(pwm_out), .wrap(wrap), .tmr_q(tmr_q)
);

// File: tb/pwm_dbuf_gen_test.sv
module pwm_dbuf_gen_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] prescale_sel = '0;
   logic [7:0] period = '0;
   logic [7:0] duty_hi = '0;
   logic [1:0] duty_lo = '0;
   logic [9:0] duty_active;
   logic       pwm_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   pwm_dbuf_gen uut (
      .clk(clk), .rst(rst), .prescale_sel(prescale_sel), .period(period),
      .duty_hi(duty_hi), .duty_lo(duty_lo),
      .duty_active(duty_active), .pwm_out(pwm_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pfac(input int code);
      return (code == 0) ? 1 : (code == 1) ? 4 : 16;
   endfunction

   task automatic set_duty(input int d);
      duty_hi = 8'(d >> 2);
      duty_lo = 2'(d & 3);
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // count low samples until the pin is seen high (stops on limit)
   task automatic wait_rise(input int limit, output int lows);
      lows = 0;
      while (pwm_out == 1'b0 && lows < limit) begin
         lows++;
         @(negedge clk);
      end
   endtask

   task automatic count_level(input logic lvl, input int limit, output int n);
      n = 0;
      while (pwm_out == lvl && n < limit) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic count_ones(input int span, output int n);
      n = 0;
      for (int i = 0; i < span; i++) begin
         if (pwm_out) n++;
         @(negedge clk);
      end
   endtask

   task automatic run_case(input int ps, input int pr, input int d);
      int p, tp, full, n, hi, lo;
      p = pfac(ps);
      tp = (pr + 1) * 4 * p;
      full = (pr + 1) * 4;
      prescale_sel = 2'(ps);
      period = 8'(pr);
      set_duty(d);
      do_reset();
      check(pwm_out == 1'b0 && duty_active == '0, "R1 reset state", int'(pwm_out), 0);
      if (d == 0) begin
         count_ones(2 * tp + 4, n);
         check(n == 0, "R6 zero duty high samples", n, 0);
      end else begin
         wait_rise(tp + 8, n);
         check(n == tp, "R1 first rise delay", n, tp);
         check(duty_active == 10'(d), "R5 shadow loaded", int'(duty_active), d);
         if (d >= full) begin
            count_ones(2 * tp, n);
            check(n == 2 * tp, "R7 over-period stays high", n, 2 * tp);
         end else begin
            count_level(1'b1, tp + 8, hi);
            count_level(1'b0, tp + 8, lo);
            check(hi == d * p, "R3 high time", hi, d * p);
            check(hi + lo == tp, "R2 period", hi + lo, tp);
         end
      end
   endtask

   initial begin
      int lim, n, hi, lo;
      // exhaustive duty sweep over small periods and every prescale code
      for (int ps = 0; ps < 4; ps++)
         for (int k = 0; k < 3; k++) begin
            int pr;
            pr = (k == 0) ? 0 : (k == 1) ? 1 : 3;
            lim = (pr + 1) * 4 + 1;
            for (int d = 0; d <= lim; d++) run_case(ps, pr, d);
         end
      // one long period
      run_case(1, 200, 333);

      // R4: duty rewritten inside a running pulse
      prescale_sel = 2'd1; period = 8'd3; set_duty(5);
      do_reset();
      wait_rise(200, n);
      set_duty(11);
      count_level(1'b1, 200, hi);
      check(hi == 20, "R4 current pulse keeps old duty", hi, 20);
      check(duty_active == 10'd5, "R5 shadow unchanged mid-period", int'(duty_active), 5);
      count_level(1'b0, 200, lo);
      check(hi + lo == 64, "R2 period across rewrite", hi + lo, 64);
      count_level(1'b1, 200, hi);
      check(hi == 44, "R4 next pulse uses new duty", hi, 44);
      check(duty_active == 10'd11, "R5 shadow after boundary", int'(duty_active), 11);

      // R8 / R6: switching to zero turns the output off from the next boundary on
      set_duty(0);
      count_level(1'b0, 200, lo);
      count_ones(130, n);
      check(n == 0, "R6 R8 no rise with zero duty", n, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule